// File: doc/BRIEF.md
# CAN Controller Control Register

This block is the main control register of a CAN protocol controller, together with the side effects that its fields drive. Software reaches it through a single-register write strobe and a continuous read-back word. The register holds the mode bits of the controller: an initialisation flag, configuration-write enable, test mode, auto-bus-on, disabling of automatic retransmission, a parity mode code, the interrupt line enable, DMA enables for two message-interface register sets, a self-clearing software reset, and the choice of how debug entry treats a frame in flight.

The CAN bit engine, the message RAM and the interface register sets are outside the block. They are represented by event, busy and access-strobe inputs. From these inputs the block produces gated DMA requests that stay latched until serviced, a gated and registered interrupt line, a one-cycle soft reset pulse, a configuration-write permission, and a debug-entry handshake whose reached state is reported in the read-back word.

Top module: `can_ctrl_reg`

## Requirements
- R1: After reset `rd_data_o` reads 0x00001401. Init (bit 0) is 1, the parity code (bits 13:10) is 5, and every other bit is 0.
- R2: Bits 19, 18, 17, 13:10, 9, 8, 7, 6, 5 and 0 are written from `wr_data_i` on a cycle with `wr_en_i` high. Bit 16 is read-only. Bits 31:20, 14 and 4:1 always read 0, and writes to them are ignored.
- R3: `dma_req_o[k]` rises one cycle after `dma_evt_i[k]` while the enable is set (bit 18 for k=0, bit 19 for k=1). An event that arrives while the enable is clear is ignored.
- R4: A pending `dma_req_o[k]` stays high through accesses to the other interface. It falls one cycle after the first `if_access_i[k]`.
- R5: `irq_o` equals `irq_pend_i` AND bit 17, delayed by one cycle. It is held low while bit 17 is 0.
- R6: A write with bit 15 set, made while Init already reads 1, makes bit 15 read 1 and `soft_rst_o` go high for exactly one cycle. On the next cycle every field returns to its R1 value and pending DMA requests clear.
- R7: A write with bit 15 set, made while Init reads 0, produces no `soft_rst_o` pulse, and bit 15 reads 0.
- R8: `parity_en_o` is 0 when bits 13:10 hold 5 and 1 for any other code.
- R9: `cfg_wr_ok_o` is 1 exactly when bit 6 and bit 0 are both 1.
- R10: With bit 8 clear, a debug request (`dbg_req_i`) made while `frame_busy_i` is high waits. Bit 16 reads 1 one cycle after `frame_busy_i` falls, and `frame_abort_o` stays 0.
- R11: With bit 8 set, a debug request made while `frame_busy_i` is high drives `frame_abort_o` high in that same cycle. Bit 16 reads 1 one cycle later.
- R12: Once debug is active, dropping `dbg_req_i` makes bit 16 read 0 one cycle later.
- R13: `auto_bus_on_o`, `test_mode_o`, `no_retx_o` and `init_o` follow bits 9, 7, 5 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Register read-back |
| dma_evt_i | input | 2 | DMA request events from interfaces 1 and 2 |
| if_access_i | input | 2 | Access strobes to interface register sets 1 and 2 |
| dma_req_o | output | 2 | Gated, latched DMA requests |
| irq_pend_i | input | 1 | Any interrupt pending |
| irq_o | output | 1 | Gated interrupt line |
| soft_rst_o | output | 1 | One-cycle soft reset pulse |
| cfg_wr_ok_o | output | 1 | Configuration registers writable |
| parity_en_o | output | 1 | Parity function enabled |
| auto_bus_on_o | output | 1 | Auto-bus-on enabled |
| test_mode_o | output | 1 | Test mode selected |
| no_retx_o | output | 1 | Automatic retransmission disabled |
| init_o | output | 1 | Initialisation flag |
| dbg_req_i | input | 1 | Debug or suspend request |
| frame_busy_i | input | 1 | Frame transmission or reception in progress |
| frame_abort_o | output | 1 | Abort the frame in flight to enter debug |

## Verification
The DMA latches are driven with a pending event on one interface followed by accesses first to the other interface and then to its own. This separates a latch that holds correctly from one that clears on any access. Soft reset is requested once with Init set and once with Init clear, which shows whether the pulse is gated and whether it really restores every field. Debug entry is requested with the frame busy under both settings of the entry-mode bit, which distinguishes waiting from aborting. The parity code is swept through 5 and its neighbours to show that only that one code turns parity off.

// File: rtl/can_ctrl_pkg.sv
package can_ctrl_pkg;
  localparam int REG_W       = 32;
  localparam int N_IF        = 2;
  localparam int PAR_W       = 4;
  localparam logic [PAR_W-1:0] PAR_OFF = 4'd5;

  // bit positions in the control word
  localparam int B_INIT      = 0;
  localparam int B_NO_RETX   = 5;
  localparam int B_CCE       = 6;
  localparam int B_TEST      = 7;
  localparam int B_DBG_ABORT = 8;
  localparam int B_ABO       = 9;
  localparam int B_PAR_LO    = 10;
  localparam int B_SWR       = 15;
  localparam int B_DBG_ST    = 16;
  localparam int B_IRQ_EN    = 17;
  localparam int B_DMA_EN    = 18;  // interface k at B_DMA_EN+k

  typedef enum logic [1:0] {
    DBG_IDLE   = 2'd0,
    DBG_WAIT   = 2'd1,
    DBG_ACTIVE = 2'd2
  } dbg_state_e;

  typedef struct packed {
    logic [N_IF-1:0]  dma_en;
    logic             irq_en;
    logic             swr;
    logic [PAR_W-1:0] par_mode;
    logic             abo;
    logic             dbg_abort;
    logic             test;
    logic             cce;
    logic             no_retx;
    logic             init;
  } ctrl_fields_t;

  localparam ctrl_fields_t CTRL_RST = '{
    dma_en:    '0,
    irq_en:    1'b0,
    swr:       1'b0,
    par_mode:  PAR_OFF,
    abo:       1'b0,
    dbg_abort: 1'b0,
    test:      1'b0,
    cce:       1'b0,
    no_retx:   1'b0,
    init:      1'b1
  };
endpackage

// File: rtl/can_ctrl_regs.sv
module can_ctrl_regs
  import can_ctrl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             dbg_active_i,
  output ctrl_fields_t     fields_o,
  output logic             soft_rst_o,
  output logic [REG_W-1:0] rd_data_o
);
  ctrl_fields_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= CTRL_RST;
    end else if (q.swr) begin
      q <= CTRL_RST;
    end else if (wr_en_i) begin
      q.dma_en    <= wr_data_i[B_DMA_EN +: N_IF];
      q.irq_en    <= wr_data_i[B_IRQ_EN];
      q.swr       <= wr_data_i[B_SWR] & q.init;  // accepted only under Init
      q.par_mode  <= wr_data_i[B_PAR_LO +: PAR_W];
      q.abo       <= wr_data_i[B_ABO];
      q.dbg_abort <= wr_data_i[B_DBG_ABORT];
      q.test      <= wr_data_i[B_TEST];
      q.cce       <= wr_data_i[B_CCE];
      q.no_retx   <= wr_data_i[B_NO_RETX];
      q.init      <= wr_data_i[B_INIT];
    end
  end

  always_comb begin
    rd_data_o                         = '0;
    rd_data_o[B_DMA_EN +: N_IF]       = q.dma_en;
    rd_data_o[B_IRQ_EN]               = q.irq_en;
    rd_data_o[B_DBG_ST]               = dbg_active_i;
    rd_data_o[B_SWR]                  = q.swr;
    rd_data_o[B_PAR_LO +: PAR_W]      = q.par_mode;
    rd_data_o[B_ABO]                  = q.abo;
    rd_data_o[B_DBG_ABORT]            = q.dbg_abort;
    rd_data_o[B_TEST]                 = q.test;
    rd_data_o[B_CCE]                  = q.cce;
    rd_data_o[B_NO_RETX]              = q.no_retx;
    rd_data_o[B_INIT]                 = q.init;
  end

  logic wr_unused;
  assign wr_unused = ^{wr_data_i[REG_W-1:B_DMA_EN+N_IF], wr_data_i[B_DBG_ST],
                       wr_data_i[B_PAR_LO+PAR_W], wr_data_i[B_NO_RETX-1:B_INIT+1]};

  assign fields_o   = q;
  assign soft_rst_o = q.swr;
endmodule

// File: rtl/can_dma_pend.sv
module can_dma_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic evt_i,
  input  logic access_i,
  output logic req_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             pend_q <= 1'b0;
    else if (clr_i)          pend_q <= 1'b0;
    else if (evt_i && en_i)  pend_q <= 1'b1;  // new request wins over access
    else if (access_i)       pend_q <= 1'b0;
  end

  assign req_o = pend_q & en_i;
endmodule

// File: rtl/can_irq_gate.sv
module can_irq_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pend_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= pend_i & en_i;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/can_dbg_entry.sv
module can_dbg_entry
  import can_ctrl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic req_i,
  input  logic busy_i,
  input  logic abort_mode_i,
  output logic active_o,
  output logic abort_o
);
  dbg_state_e st_q, st_d;

  always_comb begin
    st_d    = st_q;
    abort_o = 1'b0;
    unique case (st_q)
      DBG_IDLE, DBG_WAIT: begin
        if (!req_i) begin
          st_d = DBG_IDLE;
        end else if (abort_mode_i || !busy_i) begin
          st_d    = DBG_ACTIVE;
          abort_o = busy_i;
        end else begin
          st_d = DBG_WAIT;
        end
      end
      DBG_ACTIVE: if (!req_i) st_d = DBG_IDLE;
      default:    st_d = DBG_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    st_q <= DBG_IDLE;
    else if (clr_i) st_q <= DBG_IDLE;
    else            st_q <= st_d;
  end

  assign active_o = (st_q == DBG_ACTIVE);
endmodule

// File: rtl/can_ctrl_reg.sv
module can_ctrl_reg
  import can_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [31:0]       wr_data_i,
  output logic [31:0]       rd_data_o,
  input  logic [1:0]        dma_evt_i,
  input  logic [1:0]        if_access_i,
  output logic [1:0]        dma_req_o,
  input  logic              irq_pend_i,
  output logic              irq_o,
  output logic              soft_rst_o,
  output logic              cfg_wr_ok_o,
  output logic              parity_en_o,
  output logic              auto_bus_on_o,
  output logic              test_mode_o,
  output logic              no_retx_o,
  output logic              init_o,
  input  logic              dbg_req_i,
  input  logic              frame_busy_i,
  output logic              frame_abort_o
);
  ctrl_fields_t f;
  logic         swr;
  logic         dbg_active;

  can_ctrl_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .dbg_active_i (dbg_active),
    .fields_o     (f),
    .soft_rst_o   (swr),
    .rd_data_o    (rd_data_o)
  );

  for (genvar k = 0; k < N_IF; k++) begin : g_dma
    can_dma_pend u_pend (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (swr),
      .en_i     (f.dma_en[k]),
      .evt_i    (dma_evt_i[k]),
      .access_i (if_access_i[k]),
      .req_o    (dma_req_o[k])
    );
  end

  can_irq_gate u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (f.irq_en),
    .pend_i (irq_pend_i),
    .irq_o  (irq_o)
  );

  can_dbg_entry u_dbg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (swr),
    .req_i        (dbg_req_i),
    .busy_i       (frame_busy_i),
    .abort_mode_i (f.dbg_abort),
    .active_o     (dbg_active),
    .abort_o      (frame_abort_o)
  );

  assign soft_rst_o    = swr;
  assign cfg_wr_ok_o   = f.cce & f.init;
  assign parity_en_o   = (f.par_mode != PAR_OFF);
  assign auto_bus_on_o = f.abo;
  assign test_mode_o   = f.test;
  assign no_retx_o     = f.no_retx;
  assign init_o        = f.init;
endmodule

// File: rtl/can_ctrl_chk.sv
module can_ctrl_chk
  import can_ctrl_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] rd_data_i,
  input logic [1:0]  dma_evt_i,
  input logic [1:0]  if_access_i,
  input logic [1:0]  dma_req_i,
  input logic        irq_pend_i,
  input logic        irq_i,
  input logic        soft_rst_i,
  input logic        cfg_wr_ok_i,
  input logic        dbg_req_i,
  input logic        frame_busy_i
);
  logic rd_unused;
  assign rd_unused = ^rd_data_i;

  assert_dma_gate0_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_i[0] |-> rd_data_i[B_DMA_EN]);
  assert_dma_gate1_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_i[1] |-> rd_data_i[B_DMA_EN+1]);

  assert_dma_clear0_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_i[0] && if_access_i[0] && !dma_evt_i[0] |=> !dma_req_i[0]);
  assert_dma_clear1_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_i[1] && if_access_i[1] && !dma_evt_i[1] |=> !dma_req_i[1]);

  assert_irq_follow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i == $past(irq_pend_i && rd_data_i[B_IRQ_EN]));

  assert_swr_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !soft_rst_i && rd_data_i[B_INIT] && rd_data_i[B_PAR_LO +: PAR_W] == PAR_OFF);

  assert_swr_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(soft_rst_i) |-> $past(rd_data_i[B_INIT]));

  assert_cfg_perm_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_ok_i |-> rd_data_i[B_CCE] && rd_data_i[B_INIT]);

  assert_dbg_entry_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_data_i[B_DBG_ST]) |->
      $past(dbg_req_i) && ($past(rd_data_i[B_DBG_ABORT]) || !$past(frame_busy_i)));

  assert_dbg_exit_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_i[B_DBG_ST] && !dbg_req_i |=> !rd_data_i[B_DBG_ST]);
endmodule

bind can_ctrl_reg can_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rd_data_i    (rd_data_o),
  .dma_evt_i    (dma_evt_i),
  .if_access_i  (if_access_i),
  .dma_req_i    (dma_req_o),
  .irq_pend_i   (irq_pend_i),
  .irq_i        (irq_o),
  .soft_rst_i   (soft_rst_o),
  .cfg_wr_ok_i  (cfg_wr_ok_o),
  .dbg_req_i    (dbg_req_i),
  .frame_busy_i (frame_busy_i)
);

// File: tb/can_ctrl_reg_tb.sv
module can_ctrl_reg_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [1:0]  dma_evt = '0;
  logic [1:0]  if_access = '0;
  logic [1:0]  dma_req;
  logic        irq_pend = 1'b0;
  logic        irq;
  logic        soft_rst, cfg_ok, par_en, abo, test_m, no_retx, init;
  logic        dbg_req = 1'b0;
  logic        busy = 1'b0;
  logic        abort;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;  // 125 MHz

  can_ctrl_reg u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en),
    .wr_data_i     (wr_data),
    .rd_data_o     (rd_data),
    .dma_evt_i     (dma_evt),
    .if_access_i   (if_access),
    .dma_req_o     (dma_req),
    .irq_pend_i    (irq_pend),
    .irq_o         (irq),
    .soft_rst_o    (soft_rst),
    .cfg_wr_ok_o   (cfg_ok),
    .parity_en_o   (par_en),
    .auto_bus_on_o (abo),
    .test_mode_o   (test_m),
    .no_retx_o     (no_retx),
    .init_o        (init),
    .dbg_req_i     (dbg_req),
    .frame_busy_i  (busy),
    .frame_abort_o (abort)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%08h expected 0x%08h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "reset word", rd_data, 32'h0000_1401);
    chk("R1", "reset outputs", {30'd0, soft_rst, init}, 32'h1);
    chk("R1", "reset dma/irq", {29'd0, dma_req, irq}, 32'h0);
  endtask

  task automatic t_fields;
    wr(32'hFFFF_7FFF);
    chk("R2", "all-ones write readback", rd_data, 32'h000E_3FE1);
    wr(32'h0000_0000);
    chk("R2", "all-zero write readback", rd_data, 32'h0);
    wr(32'h0000_0001);
  endtask

  task automatic t_dma;
    wr(32'h0004_0001);  // only interface 1 enabled (bit 18)
    @(negedge clk); dma_evt = 2'b11;
    @(negedge clk); dma_evt = 2'b00;
    chk("R3", "enabled req set, disabled ignored", {30'd0, dma_req}, 32'h1);
    if_access = 2'b10;
    @(negedge clk); if_access = 2'b00;
    chk("R4", "survives other-interface access", {30'd0, dma_req}, 32'h1);
    @(negedge clk);
    chk("R4", "still pending with no access", {30'd0, dma_req}, 32'h1);
    if_access = 2'b01;
    @(negedge clk); if_access = 2'b00;
    chk("R4", "cleared by own access", {30'd0, dma_req}, 32'h0);
    wr(32'h000C_0001);
    dma_evt = 2'b10;
    @(negedge clk); dma_evt = 2'b00;
    chk("R3", "interface 2 via bit 19", {30'd0, dma_req}, 32'h2);
    if_access = 2'b01;
    @(negedge clk); if_access = 2'b00;
    chk("R4", "if2 survives if1 access", {30'd0, dma_req}, 32'h2);
    if_access = 2'b10;
    @(negedge clk); if_access = 2'b00;
    chk("R4", "if2 cleared by own access", {30'd0, dma_req}, 32'h0);
  endtask

  task automatic t_irq;
    wr(32'h0000_0001);
    irq_pend = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R5", "masked while disabled", {31'd0, irq}, 32'h0);
    wr(32'h0002_0001);
    @(negedge clk);
    chk("R5", "asserted when enabled", {31'd0, irq}, 32'h1);
    irq_pend = 1'b0;
    @(negedge clk);
    chk("R5", "drops after service", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_swr_reject;
    wr(32'h0000_0000);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 32'h0000_8000;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R7", "no pulse without Init", {31'd0, soft_rst}, 32'h0);
    chk("R7", "swr bit reads 0", rd_data, 32'h0);
    @(negedge clk);
    chk("R7", "still no pulse", {31'd0, soft_rst}, 32'h0);
  endtask

  task automatic t_swr_accept;
    wr(32'h000C_0EE1);
    dma_evt = 2'b11;
    @(negedge clk); dma_evt = 2'b00;
    chk("R6", "dma pending before reset", {30'd0, dma_req}, 32'h3);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 32'h000C_8EE1;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R6", "pulse cycle readback", rd_data, 32'h000C_8EE1);
    chk("R6", "pulse high", {31'd0, soft_rst}, 32'h1);
    @(negedge clk);
    chk("R6", "fields restored", rd_data, 32'h0000_1401);
    chk("R6", "pulse single cycle", {31'd0, soft_rst}, 32'h0);
    chk("R6", "dma cleared", {30'd0, dma_req}, 32'h0);
  endtask

  task automatic t_parity;
    wr(32'h0000_1401);
    chk("R8", "code 5 disables", {31'd0, par_en}, 32'h0);
    wr(32'h0000_1801);
    chk("R8", "code 6 enables", {31'd0, par_en}, 32'h1);
    wr(32'h0000_1001);
    chk("R8", "code 4 enables", {31'd0, par_en}, 32'h1);
    wr(32'h0000_0001);
    chk("R8", "code 0 enables", {31'd0, par_en}, 32'h1);
  endtask

  task automatic t_cfg;
    wr(32'h0000_0041);
    chk("R9", "cce and init", {31'd0, cfg_ok}, 32'h1);
    wr(32'h0000_0040);
    chk("R9", "cce without init", {31'd0, cfg_ok}, 32'h0);
    wr(32'h0000_0001);
    chk("R9", "init without cce", {31'd0, cfg_ok}, 32'h0);
  endtask

  task automatic t_modes;
    wr(32'h0000_02A1);
    chk("R13", "modes set", {28'd0, abo, test_m, no_retx, init}, 32'hF);
    wr(32'h0000_0000);
    chk("R13", "modes clear", {28'd0, abo, test_m, no_retx, init}, 32'h0);
    wr(32'h0000_0001);
  endtask

  task automatic t_dbg_wait;
    wr(32'h0000_0001);
    busy = 1'b1; dbg_req = 1'b1;
    #1;
    chk("R10", "no abort in wait mode", {31'd0, abort}, 32'h0);
    @(negedge clk);
    chk("R10", "not active while busy", {31'd0, rd_data[16]}, 32'h0);
    @(negedge clk);
    chk("R10", "still waiting", {31'd0, rd_data[16]}, 32'h0);
    busy = 1'b0;
    @(negedge clk);
    chk("R10", "active after frame end", {31'd0, rd_data[16]}, 32'h1);
    dbg_req = 1'b0;
    @(negedge clk);
    chk("R12", "exit on request drop", {31'd0, rd_data[16]}, 32'h0);
  endtask

  task automatic t_dbg_abort;
    wr(32'h0000_0101);
    busy = 1'b1; dbg_req = 1'b1;
    #1;
    chk("R11", "abort raised", {31'd0, abort}, 32'h1);
    chk("R11", "not yet active", {31'd0, rd_data[16]}, 32'h0);
    @(negedge clk);
    chk("R11", "active immediately", {31'd0, rd_data[16]}, 32'h1);
    chk("R11", "abort released", {31'd0, abort}, 32'h0);
    dbg_req = 1'b0; busy = 1'b0;
    @(negedge clk);
    chk("R12", "exit after abort entry", {31'd0, rd_data[16]}, 32'h0);
    wr(32'h0001_0001);
    chk("R2", "bit 16 not writable", {31'd0, rd_data[16]}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_dma();
    t_irq();
    t_swr_reject();
    t_swr_accept();
    t_parity();
    t_cfg();
    t_modes();
    t_dbg_wait();
    t_dbg_abort();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule